// File: doc/BRIEF.md
# Logic Self-Test Stimulus Generator

This block is the control and stimulus half of an at-speed logic self-test engine. It is placed next to a logic core made of three sub-modules. A test controller loads a pattern count and pulses a start strobe. From then on the block applies one pseudo-random pattern per clock to all three sub-modules at once. When the count runs out it drops its test-enable output and raises an end-of-test flag. Response compaction lives elsewhere.

All random data comes from one 20-bit Galois LFSR. On each module port wider than the register, the LFSR bits are repeated cyclically until the port is full. Two of the modules have a 4-bit datapath-select input. Random values there would waste most patterns on narrow datapaths. A small constraint generator therefore drives that field: it holds the widest-datapath code most of the time and visits each of the other codes briefly. The third module takes pure LFSR data.

Top module: `lbist_stim_gen`

## Requirements
- R1: After reset, test_en_o and done_o are 0 and all three stimulus buses are 0.
- R2: A start_i pulse sampled while no test is running, with a nonzero count_i of N, raises test_en_o on the next cycle. test_en_o then stays high for exactly N cycles, so at most 4095 patterns are applied per run. Exactly one pattern is presented on each of those cycles.
- R3: done_o rises in the same cycle that test_en_o falls. It stays high until the next accepted start clears it. done_o and test_en_o are never high together.
- R4: A start with count_i equal to 0 applies no pattern. It raises done_o on the next cycle, and test_en_o stays 0.
- R5: A start_i pulse or a change of count_i while test_en_o is high is ignored, so the run length is the count latched at launch.
- R6: The random source is a right-shifting Galois LFSR for x^20+x^17+1. Each step shifts the state right by one, and when the bit shifted out is 1 the toggle mask 20'h90000 is XORed in. The seed 20'h00001 is reloaded at every accepted start. Pattern 0 of a run uses the seed, and the state steps once per applied pattern.
- R7: Bit i of stim_c_o (45 bits) equals LFSR bit i mod 20.
- R8: stim_a_o (54 bits) carries the select code in bits [53:50], and bit i of [49:0] equals LFSR bit i mod 20.
- R9: stim_b_o (53 bits) carries the same select code in bits [52:49], and bit i of [48:0] equals LFSR bit i mod 20.
- R10: For pattern index k within a run (k starts at 0), the select code is 4'hF when k mod 16 is not 15. Otherwise it is (k div 16) mod 15, so the codes 0 to 14 are visited in rising order and then wrap.
- R11: While test_en_o is 0, all three stimulus buses are driven to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch strobe, sampled on the rising edge |
| count_i | input | 12 | Number of patterns for the run, latched at launch |
| test_en_o | output | 1 | High while patterns are being applied |
| done_o | output | 1 | End-of-test flag, held until the next launch |
| stim_a_o | output | 54 | Stimulus for module A: select code on top, replicated LFSR below |
| stim_b_o | output | 53 | Stimulus for module B: select code on top, replicated LFSR below |
| stim_c_o | output | 45 | Stimulus for module C: replicated LFSR only |

## Verification
The properties assume that a run only begins from idle, so the checker's own pattern index starts from zero on every rising edge of test_en_o. They also assume that start_i is the sole way in, so the select field can only depart from 4'hF on every sixteenth pattern. The stimulus keeps to this. Starts are issued only after the previous run has ended, apart from deliberate mid-run pulses that test R5. Runs are long enough to pass through the select wrap, and one run uses the full 4095-pattern count.

// File: rtl/lbist_pkg.sv
package lbist_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_END  = 2'd2
   } run_state_t;

endpackage

// File: rtl/lbist_seq_ctrl.sv
module lbist_seq_ctrl
   import lbist_pkg::*;
#(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [CNT_W-1:0] count_i,
   output logic             launch_o,
   output logic             run_o,
   output logic             end_o
);

   localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
   localparam logic [CNT_W-1:0] ZERO = '0;

   run_state_t       state_q;
   logic [CNT_W-1:0] left_q;
   logic             accept;

   assign accept   = start_i && (state_q != ST_RUN);
   assign launch_o = accept && (count_i != ZERO);
   assign run_o    = (state_q == ST_RUN);
   assign end_o    = (state_q == ST_END);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         left_q  <= ZERO;
      end else if (accept) begin
         left_q  <= count_i;
         state_q <= (count_i == ZERO) ? ST_END : ST_RUN;
      end else if (state_q == ST_RUN) begin
         left_q <= left_q - ONE;
         if (left_q == ONE) begin
            state_q <= ST_END;
         end
      end
   end

endmodule

// File: rtl/lbist_galois_lfsr.sv
module lbist_galois_lfsr #(
   parameter int          W    = 20,
   parameter logic [W-1:0] MASK = 20'h90000,
   parameter logic [W-1:0] SEED = 20'h00001
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic         step_i,
   output logic [W-1:0] state_o
);

   logic [W-1:0] state_q;
   logic [W-1:0] shifted;
   logic [W-1:0] next_state;

   if (SEED == '0) begin : g_bad_seed
      $error("lbist_galois_lfsr: seed must be nonzero");
   end
   if (MASK[W-1] != 1'b1) begin : g_bad_mask
      $error("lbist_galois_lfsr: mask must include the top term");
   end

   assign shifted    = state_q >> 1;
   assign next_state = state_q[0] ? (shifted ^ MASK) : shifted;
   assign state_o    = state_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEED;
      end else if (load_i) begin
         state_q <= SEED;
      end else if (step_i) begin
         state_q <= next_state;
      end
   end

endmodule

// File: rtl/lbist_constraint_gen.sv
module lbist_constraint_gen #(
   parameter int SEL_W    = 4,
   parameter int HOLD_LEN = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart_i,
   input  logic             advance_i,
   output logic [SEL_W-1:0] sel_o
);

   localparam int               PH_W      = (HOLD_LEN > 1) ? $clog2(HOLD_LEN) : 1;
   localparam logic [PH_W-1:0]  PH_LAST   = PH_W'(HOLD_LEN - 1);
   localparam logic [SEL_W-1:0] WIDE_CODE = '1;
   localparam logic [SEL_W-1:0] LAST_CODE = SEL_W'((2 ** SEL_W) - 2);
   localparam logic [SEL_W-1:0] SEL_ONE   = {{(SEL_W-1){1'b0}}, 1'b1};

   if (HOLD_LEN < 2 || (HOLD_LEN & (HOLD_LEN - 1)) != 0) begin : g_bad_hold
      $error("lbist_constraint_gen: HOLD_LEN must be a power of two >= 2");
   end
   if (SEL_W < 2) begin : g_bad_sel
      $error("lbist_constraint_gen: SEL_W must be at least 2");
   end

   logic [PH_W-1:0]  phase_q;
   logic [SEL_W-1:0] step_q;
   logic             slot_open;

   assign slot_open = (phase_q == PH_LAST);
   assign sel_o     = slot_open ? step_q : WIDE_CODE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
         step_q  <= '0;
      end else if (restart_i) begin
         phase_q <= '0;
         step_q  <= '0;
      end else if (advance_i) begin
         phase_q <= phase_q + PH_W'(1);
         if (slot_open) begin
            step_q <= (step_q == LAST_CODE) ? '0 : (step_q + SEL_ONE);
         end
      end
   end

endmodule

// File: rtl/lbist_port_fill.sv
module lbist_port_fill #(
   parameter int SRC_W = 20,
   parameter int DST_W = 50
) (
   input  logic [SRC_W-1:0] src_i,
   output logic [DST_W-1:0] dst_o
);

   if (DST_W < 1 || SRC_W < 1) begin : g_bad_w
      $error("lbist_port_fill: widths must be positive");
   end

   if (DST_W <= SRC_W) begin : g_slice
      assign dst_o = src_i[DST_W-1:0];
   end else begin : g_repl
      for (genvar i = 0; i < DST_W; i++) begin : g_bit
         assign dst_o[i] = src_i[i % SRC_W];
      end
   end

endmodule

// File: rtl/lbist_stim_gen.sv
module lbist_stim_gen #(
   parameter int              CNT_W    = 12,
   parameter int              LFSR_W   = 20,
   parameter logic [LFSR_W-1:0] LFSR_MASK = 20'h90000,
   parameter logic [LFSR_W-1:0] LFSR_SEED = 20'h00001,
   parameter int              SEL_W    = 4,
   parameter int              HOLD_LEN = 16,
   parameter int              A_W      = 54,
   parameter int              B_W      = 53,
   parameter int              C_W      = 45
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [CNT_W-1:0] count_i,
   output logic             test_en_o,
   output logic             done_o,
   output logic [A_W-1:0]   stim_a_o,
   output logic [B_W-1:0]   stim_b_o,
   output logic [C_W-1:0]   stim_c_o
);

   localparam int A_BODY = A_W - SEL_W;
   localparam int B_BODY = B_W - SEL_W;

   if (A_BODY < 1 || B_BODY < 1) begin : g_bad_ports
      $error("lbist_stim_gen: constrained ports must be wider than the select field");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("lbist_stim_gen: CNT_W must be positive");
   end

   logic              launch;
   logic              running;
   logic [LFSR_W-1:0] rnd;
   logic [SEL_W-1:0]  sel;
   logic [A_BODY-1:0] a_body;
   logic [B_BODY-1:0] b_body;
   logic [C_W-1:0]    c_body;

   lbist_seq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .count_i  (count_i),
      .launch_o (launch),
      .run_o    (running),
      .end_o    (done_o)
   );

   lbist_galois_lfsr #(.W(LFSR_W), .MASK(LFSR_MASK), .SEED(LFSR_SEED)) u_lfsr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (launch),
      .step_i  (running),
      .state_o (rnd)
   );

   lbist_constraint_gen #(.SEL_W(SEL_W), .HOLD_LEN(HOLD_LEN)) u_cgen (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart_i (launch),
      .advance_i (running),
      .sel_o     (sel)
   );

   lbist_port_fill #(.SRC_W(LFSR_W), .DST_W(A_BODY)) u_fill_a (.src_i(rnd), .dst_o(a_body));
   lbist_port_fill #(.SRC_W(LFSR_W), .DST_W(B_BODY)) u_fill_b (.src_i(rnd), .dst_o(b_body));
   lbist_port_fill #(.SRC_W(LFSR_W), .DST_W(C_W))    u_fill_c (.src_i(rnd), .dst_o(c_body));

   assign test_en_o = running;
   assign stim_a_o  = running ? {sel, a_body} : '0;
   assign stim_b_o  = running ? {sel, b_body} : '0;
   assign stim_c_o  = running ? c_body : '0;

endmodule

// File: rtl/lbist_stim_gen_chk.sv
module lbist_stim_gen_chk #(
   parameter int LFSR_W   = 20,
   parameter int SEL_W    = 4,
   parameter int HOLD_LEN = 16,
   parameter int A_W      = 54,
   parameter int B_W      = 53,
   parameter int C_W      = 45
) (
   input logic           clk,
   input logic           rst_n,
   input logic           test_en,
   input logic           done,
   input logic [A_W-1:0] stim_a,
   input logic [B_W-1:0] stim_b,
   input logic [C_W-1:0] stim_c
);

   localparam int IDX_W = $clog2(HOLD_LEN);

   logic [31:0] pat_idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pat_idx <= '0;
      else if (!test_en) pat_idx <= '0;
      else               pat_idx <= pat_idx + 32'd1;
   end

   p_en_done_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(test_en && done));

   p_end_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(test_en) |-> done);

   p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !test_en |-> (stim_a == '0 && stim_b == '0 && stim_c == '0));

   p_lfsr_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
      test_en |-> (stim_c[LFSR_W-1:0] != '0));

   p_sel_shared_r9: assert property (@(posedge clk) disable iff (!rst_n)
      test_en |-> (stim_a[A_W-1 -: SEL_W] == stim_b[B_W-1 -: SEL_W]));

   p_sel_wide_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (test_en && pat_idx[IDX_W-1:0] != IDX_W'(HOLD_LEN - 1))
         |-> (stim_a[A_W-1 -: SEL_W] == '1));

   if (A_W - SEL_W >= 2 * LFSR_W) begin : g_repl_chk
      p_repl_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
         test_en |-> (stim_a[2*LFSR_W-1:LFSR_W] == stim_a[LFSR_W-1:0]));
   end

endmodule

bind lbist_stim_gen lbist_stim_gen_chk #(
   .LFSR_W(LFSR_W), .SEL_W(SEL_W), .HOLD_LEN(HOLD_LEN),
   .A_W(A_W), .B_W(B_W), .C_W(C_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .test_en (test_en_o),
   .done    (done_o),
   .stim_a  (stim_a_o),
   .stim_b  (stim_b_o),
   .stim_c  (stim_c_o)
);

// File: tb/test_lbist_stim_gen.sv
`timescale 1ns/1ps
module test_lbist_stim_gen;

   typedef struct packed {
      logic [53:0] a;
      logic [52:0] b;
      logic [44:0] c;
   } stim_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [11:0] count_i = '0;
   logic        test_en_o, done_o;
   logic [53:0] stim_a_o;
   logic [52:0] stim_b_o;
   logic [44:0] stim_c_o;

   int checks = 0;
   int failures = 0;
   int pat_seen = 0;
   stim_t exp_q[$];

   always #2.5 clk = ~clk;

   lbist_stim_gen i_lbist_stim_gen (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .count_i(count_i),
      .test_en_o(test_en_o), .done_o(done_o),
      .stim_a_o(stim_a_o), .stim_b_o(stim_b_o), .stim_c_o(stim_c_o)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [19:0] lfsr_next(input logic [19:0] s);
      logic [19:0] r;
      r = {1'b0, s[19:1]};
      if (s[0]) r = r ^ 20'h90000;
      return r;
   endfunction

   // Driver side: expected stimulus for N patterns (R6..R10)
   task automatic push_expected(input int n);
      logic [19:0] s = 20'h00001;
      for (int k = 0; k < n; k++) begin
         stim_t e;
         logic [3:0] sel;
         sel = ((k % 16) != 15) ? 4'hF : 4'((k / 16) % 15);
         for (int i = 0; i < 50; i++) e.a[i] = s[i % 20];
         for (int i = 0; i < 49; i++) e.b[i] = s[i % 20];
         for (int i = 0; i < 45; i++) e.c[i] = s[i % 20];
         e.a[53:50] = sel;
         e.b[52:49] = sel;
         exp_q.push_back(e);
         s = lfsr_next(s);
      end
   endtask

   // Monitor: pops one expected item per enabled cycle
   always @(negedge clk) begin
      if (rst_n && test_en_o) begin
         pat_seen++;
         if (exp_q.size() == 0) begin
            check(1'b0, "R2", "extra pattern", 64'(pat_seen), 64'(0));
         end else begin
            stim_t e;
            e = exp_q.pop_front();
            check(stim_c_o == e.c, "R7", "stim_c", 64'(stim_c_o), 64'(e.c));
            check(stim_a_o[49:0] == e.a[49:0], "R8", "stim_a body",
                  64'(stim_a_o[49:0]), 64'(e.a[49:0]));
            check(stim_b_o[48:0] == e.b[48:0], "R9", "stim_b body",
                  64'(stim_b_o[48:0]), 64'(e.b[48:0]));
            check(stim_a_o[53:50] == e.a[53:50] && stim_b_o[52:49] == e.b[52:49],
                  "R10", "select code", 64'({stim_a_o[53:50], stim_b_o[52:49]}),
                  64'({e.a[53:50], e.b[52:49]}));
            check(!done_o, "R3", "done during run", 64'(done_o), 64'(0));
         end
      end
   end

   task automatic check_idle(input string req);
      check(stim_a_o == '0 && stim_b_o == '0 && stim_c_o == '0, req, "idle buses zero",
            64'(stim_c_o), 64'(0));
   endtask

   // Launch a run of n patterns; optionally pulse start mid-run (R5)
   task automatic run_test(input int n, input int inject_at, input logic [11:0] inject_cnt);
      push_expected(n);
      @(posedge clk); #1;
      start_i = 1'b1;
      count_i = 12'(n);
      @(posedge clk); #1;
      start_i = 1'b0;
      if (n == 0) begin
         check(done_o && !test_en_o, "R4", "zero count ends at once",
               64'({test_en_o, done_o}), 64'b01);
         repeat (3) @(posedge clk);
         #1;
         check(!test_en_o && done_o, "R4", "no pattern for zero count",
               64'({test_en_o, done_o}), 64'b01);
         check_idle("R11");
         return;
      end
      check(test_en_o && !done_o, "R2", "enable after launch",
            64'({test_en_o, done_o}), 64'b10);
      for (int c = 1; c < n; c++) begin
         if (c == inject_at) begin
            start_i = 1'b1;
            count_i = inject_cnt;
         end
         @(posedge clk); #1;
         start_i = 1'b0;
         count_i = 12'(n + 7);
      end
      @(posedge clk); #1;
      check(!test_en_o && done_o, "R3", "end flag with enable low",
            64'({test_en_o, done_o}), 64'b01);
      check(exp_q.size() == 0, "R2", "all patterns applied", 64'(exp_q.size()), 64'(0));
      check_idle("R11");
      repeat (2) @(posedge clk);
      #1;
      check(!test_en_o && done_o, "R5", "no restart after run",
            64'({test_en_o, done_o}), 64'b01);
      exp_q.delete();
   endtask

   initial begin
      #(5.0 * 100000);
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check(!test_en_o && !done_o, "R1", "reset flags", 64'({test_en_o, done_o}), 64'b00);
      check_idle("R1");
      rst_n = 1'b1;
      @(posedge clk); #1;
      check(!test_en_o && !done_o, "R1", "idle after reset", 64'({test_en_o, done_o}), 64'b00);

      run_test(5, 0, 12'd0);        // R2 short run, R6 seed
      run_test(40, 10, 12'd3);      // R5 start ignored mid-run
      run_test(0, 0, 12'd0);        // R4 zero count
      run_test(300, 0, 12'd0);      // R10 select codes wrap
      run_test(5, 0, 12'd0);        // R6 seed reloaded
      run_test(4095, 2000, 12'd1);  // R2 full count

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule